// File: doc/BRIEF.md
# Chained Descriptor Transmit DMA

This block is the transmit half of one DMA channel. Once started with a descriptor address and a context address, it walks a linked list of four-word data descriptors in memory. For each one it reads the buffer one 32-bit word at a time through a word-read memory port and sends the words out on a valid/ready stream. The last word of a buffer carries a byte count, and the last word of a packet carries an end-of-packet marker. A metadata value taken from the descriptor goes out on a sideband pulse before each packet.

When a buffer is finished, the engine writes the descriptor back to memory. It pulses an interrupt if the descriptor asks for one. It then either follows the next pointer or, at end of list, marks the context descriptor disabled and halts. A continue command lets software extend a halted list by clearing the end-of-list bit of the last descriptor. The current descriptor pointer and buffer pointer are visible at the ports. Buffers are read in chunks of at most `CHUNK_BYTES`, and the buffer pointer output moves once per chunk.

Top module: `chain_tx_dma`

## Requirements
- R1: After reset, `busy`, `eolFlag`, `outValid`, `memRdReq` and `memWrEn` are low, and `savedDescPtr` and `savedBufPtr` are zero.
- R2: A descriptor is four words at ascending addresses: next pointer, buffer start (word aligned), flags, and end address (one past the last byte). The bytes from start to end-1 leave as words read from memory, low-order byte first. `outBytes` is 4 on every beat except the final beat of a buffer, which carries the remaining count of 1 to 4.
- R3: The buffer is read in chunks of at most `CHUNK_BYTES`. `savedBufPtr` is set to the buffer start when a descriptor is taken up and advances to the current read position at the end of each chunk.
- R4: `outLast` is high only on the beat that reaches the end address, and only when flags bit 3 (packet end) is set.
- R5: `metaValid` pulses with `metaData` = flags[31:16] once before the first descriptor of a run, and again for the first descriptor after any descriptor with flags bit 3 set.
- R6: When a descriptor with flags bit 4 set is finished, `irqPulse` is high for one cycle.
- R7: A finished descriptor has its four words written back, in order, to its own address.
- R8: If flags bit 0 (end of list) is set on a finished descriptor, the engine sets `eolFlag`, reads the context flags word at context address + 4, writes it back with bit 15 set, and goes idle. At that point `savedDescPtr` holds that descriptor's address and `savedBufPtr` its end address.
- R9: If flags bit 0 is clear, the engine continues with the descriptor at the next pointer, starting from that descriptor's buffer start.
- R10: While `outValid` is high and `outReady` is low, `outValid`, `outData`, `outBytes` and `outLast` hold.
- R11: A start clears `eolFlag` and begins at `startDescPtr`. A start or continue that arrives while `busy` is high has no effect.
- R12: A continue while idle with `eolFlag` set re-reads the descriptor at `savedDescPtr`. If its end-of-list bit is still set, no beat and no write follow and `eolFlag` stays set. Otherwise the engine clears `eolFlag` and runs from that descriptor's next pointer as a new run. A continue with `eolFlag` clear is ignored.
- R13: A descriptor whose end address equals its start produces no beat but is still written back and still follows R5 to R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | Start a run (one cycle) |
| startDescPtr | input | ADDR_W | First descriptor address, sampled on start |
| startCtxPtr | input | ADDR_W | Context descriptor address, sampled on start |
| contPulse | input | 1 | Continue command (one cycle) |
| memRdReq | output | 1 | One-cycle word read request |
| memRdAddr | output | ADDR_W | Read byte address, word aligned |
| memRdValid | input | 1 | Read data returned |
| memRdData | input | 32 | Read data word |
| memWrEn | output | 1 | Word write strobe |
| memWrAddr | output | ADDR_W | Write byte address |
| memWrData | output | 32 | Write data word |
| outValid | output | 1 | Stream beat valid |
| outReady | input | 1 | Stream sink ready |
| outData | output | 32 | Stream data word |
| outBytes | output | 3 | Valid bytes in the beat, 1 to 4 |
| outLast | output | 1 | End of packet |
| metaValid | output | 1 | Metadata strobe |
| metaData | output | 16 | Packet metadata |
| irqPulse | output | 1 | Descriptor-done interrupt pulse |
| eolFlag | output | 1 | End of list reached |
| busy | output | 1 | Engine not idle |
| savedDescPtr | output | ADDR_W | Current descriptor address |
| savedBufPtr | output | ADDR_W | Buffer position at the last chunk boundary |

## Verification
The bench builds the engine with `CHUNK_BYTES` = 16 and the default 32-bit address width. With this chunk size a 40-byte buffer splits into two full chunks and one short chunk, so the per-chunk updates of the buffer pointer can be seen with a few dozen beats. The small memory model then keeps chains, zero-length buffers, random back-pressure and both outcomes of a continue within a short run.

// File: rtl/chain_tx_dma_pkg.sv
package chain_tx_dma_pkg;

  localparam int FLAG_EOL  = 0;
  localparam int FLAG_EOP  = 3;
  localparam int FLAG_IRQ  = 4;
  localparam int CTX_DIS   = 15;
  localparam int DESC_WORDS = 4;

  typedef enum logic [1:0] {RD_DESC, RD_BUF, RD_CTX} rd_sel_e;
  typedef enum logic {WR_DESC, WR_CTX} wr_sel_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DRD, ST_DWAIT, ST_DDONE, ST_META, ST_CHUNK, ST_BRD,
    ST_BWAIT, ST_PUSH, ST_CEND, ST_WB, ST_CRD, ST_CWAIT, ST_CWR
  } tx_state_e;

  typedef struct packed {
    logic       loadStart;
    logic       loadNext;
    logic       capWord;
    logic [1:0] wordIdx;
    logic       initBuf;
    logic       loadChunk;
    logic       capData;
    logic       advance;
    logic       commitBuf;
    logic       capCtx;
    logic       setEol;
    logic       clrEol;
    logic       setMeta;
    logic       clrMeta;
    rd_sel_e    rdSel;
    wr_sel_e    wrSel;
  } dp_ctrl_t;

  typedef struct packed {
    logic remainZero;
    logic chunkEnd;
    logic fEol;
    logic fEop;
    logic fIrq;
    logic eolFlag;
    logic sendMeta;
  } dp_stat_t;

endpackage

// File: rtl/chain_tx_dma_dp.sv
module chain_tx_dma_dp
  import chain_tx_dma_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CHUNK_BYTES = 2048
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_ctrl_t          ctl,
  input  logic [ADDR_W-1:0] startPtr,
  input  logic [ADDR_W-1:0] ctxPtrIn,
  input  logic [31:0]       memRdData,
  output dp_stat_t          stat,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [31:0]       memWrData,
  output logic [31:0]       outData,
  output logic [2:0]        outBytes,
  output logic              pktEnd,
  output logic [15:0]       metaData,
  output logic [ADDR_W-1:0] savedDescPtr,
  output logic [ADDR_W-1:0] savedBufPtr,
  output logic              eolFlag
);

  localparam int CW = $clog2(CHUNK_BYTES) + 1;

  logic [31:0]       descWord [DESC_WORDS];
  logic [ADDR_W-1:0] descAddr, ctxAddr, workPtr, savedBuf;
  logic [CW-1:0]     chunkLeft;
  logic [31:0]       dataReg, ctxFlags;
  logic              eolR, metaR;

  logic [ADDR_W-1:0] bufStart, afterPtr, nextPtr, remain, wordOff;
  logic [31:0]       flags;
  logic [CW-1:0]     chunkLen;
  logic [2:0]        beatBytes;

  assign nextPtr  = descWord[0][ADDR_W-1:0];
  assign bufStart = descWord[1][ADDR_W-1:0];
  assign flags    = descWord[2];
  assign afterPtr = descWord[3][ADDR_W-1:0];
  assign remain   = afterPtr - workPtr;
  assign wordOff  = {{(ADDR_W-4){1'b0}}, ctl.wordIdx, 2'b00};

  assign chunkLen  = (remain > ADDR_W'(CHUNK_BYTES)) ? CW'(CHUNK_BYTES) : remain[CW-1:0];
  assign beatBytes = (chunkLeft >= CW'(4)) ? 3'd4 : chunkLeft[2:0];

  // descriptor word capture, one per index
  for (genvar gi = 0; gi < DESC_WORDS; gi++) begin : g_desc
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) descWord[gi] <= '0;
      else if (ctl.capWord && ctl.wordIdx == 2'(gi)) descWord[gi] <= memRdData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      descAddr  <= '0;
      ctxAddr   <= '0;
      workPtr   <= '0;
      savedBuf  <= '0;
      chunkLeft <= '0;
      dataReg   <= '0;
      ctxFlags  <= '0;
      eolR      <= 1'b0;
      metaR     <= 1'b0;
    end else begin
      if (ctl.loadStart) begin
        descAddr <= startPtr;
        ctxAddr  <= ctxPtrIn;
      end else if (ctl.loadNext) begin
        descAddr <= nextPtr;
      end
      if (ctl.initBuf) begin
        workPtr  <= bufStart;
        savedBuf <= bufStart;
      end else begin
        if (ctl.advance)   workPtr  <= workPtr + {{(ADDR_W-3){1'b0}}, beatBytes};
        if (ctl.commitBuf) savedBuf <= workPtr;
      end
      if (ctl.loadChunk)    chunkLeft <= chunkLen;
      else if (ctl.advance) chunkLeft <= chunkLeft - {{(CW-3){1'b0}}, beatBytes};
      if (ctl.capData) dataReg  <= memRdData;
      if (ctl.capCtx)  ctxFlags <= memRdData;
      if (ctl.setEol)      eolR <= 1'b1;
      else if (ctl.clrEol) eolR <= 1'b0;
      if (ctl.setMeta)      metaR <= 1'b1;
      else if (ctl.clrMeta) metaR <= 1'b0;
    end
  end

  always_comb begin
    unique case (ctl.rdSel)
      RD_BUF:  memRdAddr = {workPtr[ADDR_W-1:2], 2'b00};
      RD_CTX:  memRdAddr = ctxAddr + ADDR_W'(4);
      default: memRdAddr = descAddr + wordOff;
    endcase
  end

  always_comb begin
    if (ctl.wrSel == WR_CTX) begin
      memWrAddr = ctxAddr + ADDR_W'(4);
      memWrData = ctxFlags | (32'd1 << CTX_DIS);
    end else begin
      memWrAddr = descAddr + wordOff;
      memWrData = descWord[ctl.wordIdx];
    end
  end

  assign stat.remainZero = (remain == '0);
  assign stat.chunkEnd   = (chunkLeft == {{(CW-3){1'b0}}, beatBytes});
  assign stat.fEol       = flags[FLAG_EOL];
  assign stat.fEop       = flags[FLAG_EOP];
  assign stat.fIrq       = flags[FLAG_IRQ];
  assign stat.eolFlag    = eolR;
  assign stat.sendMeta   = metaR;

  assign outData      = dataReg;
  assign outBytes     = beatBytes;
  assign pktEnd       = flags[FLAG_EOP] && (remain == {{(ADDR_W-3){1'b0}}, beatBytes});
  assign metaData     = flags[31:16];
  assign savedDescPtr = descAddr;
  assign savedBufPtr  = savedBuf;
  assign eolFlag      = eolR;

endmodule

// File: rtl/chain_tx_dma_ctrl.sv
module chain_tx_dma_ctrl
  import chain_tx_dma_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     startPulse,
  input  logic     contPulse,
  input  logic     memRdValid,
  input  logic     outReady,
  input  dp_stat_t stat,
  output dp_ctrl_t ctl,
  output logic     memRdReq,
  output logic     memWrEn,
  output logic     outValid,
  output logic     metaValid,
  output logic     irqPulse,
  output logic     busy
);

  tx_state_e state, stateNext;
  logic [1:0] wordIdx, wordIdxNext;
  logic       contLoad, contLoadNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      wordIdx  <= '0;
      contLoad <= 1'b0;
    end else begin
      state    <= stateNext;
      wordIdx  <= wordIdxNext;
      contLoad <= contLoadNext;
    end
  end

  always_comb begin
    ctl          = '0;
    ctl.rdSel    = RD_DESC;
    ctl.wrSel    = WR_DESC;
    ctl.wordIdx  = wordIdx;
    stateNext    = state;
    wordIdxNext  = wordIdx;
    contLoadNext = contLoad;
    memRdReq     = 1'b0;
    memWrEn      = 1'b0;
    outValid     = 1'b0;
    metaValid    = 1'b0;
    irqPulse     = 1'b0;

    unique case (state)
      ST_IDLE: begin
        if (startPulse) begin
          ctl.loadStart = 1'b1;
          ctl.clrEol    = 1'b1;
          ctl.setMeta   = 1'b1;
          contLoadNext  = 1'b0;
          wordIdxNext   = '0;
          stateNext     = ST_DRD;
        end else if (contPulse && stat.eolFlag && stat.fEol) begin
          contLoadNext = 1'b1;
          wordIdxNext  = '0;
          stateNext    = ST_DRD;
        end
      end
      ST_DRD: begin
        memRdReq  = 1'b1;
        stateNext = ST_DWAIT;
      end
      ST_DWAIT: begin
        if (memRdValid) begin
          ctl.capWord = 1'b1;
          if (wordIdx == 2'd3) begin
            stateNext = ST_DDONE;
          end else begin
            wordIdxNext = wordIdx + 2'd1;
            stateNext   = ST_DRD;
          end
        end
      end
      ST_DDONE: begin
        if (contLoad) begin
          if (stat.fEol) begin
            contLoadNext = 1'b0;
            stateNext    = ST_IDLE;
          end else begin
            ctl.loadNext = 1'b1;
            ctl.clrEol   = 1'b1;
            ctl.setMeta  = 1'b1;
            contLoadNext = 1'b0;
            wordIdxNext  = '0;
            stateNext    = ST_DRD;
          end
        end else begin
          stateNext = ST_META;
        end
      end
      ST_META: begin
        metaValid   = stat.sendMeta;
        ctl.clrMeta = 1'b1;
        ctl.initBuf = 1'b1;
        stateNext   = ST_CHUNK;
      end
      ST_CHUNK: begin
        if (stat.remainZero) begin
          irqPulse    = stat.fIrq;
          ctl.setMeta = stat.fEop;
          wordIdxNext = '0;
          stateNext   = ST_WB;
        end else begin
          ctl.loadChunk = 1'b1;
          stateNext     = ST_BRD;
        end
      end
      ST_BRD: begin
        memRdReq  = 1'b1;
        ctl.rdSel = RD_BUF;
        stateNext = ST_BWAIT;
      end
      ST_BWAIT: begin
        ctl.rdSel = RD_BUF;
        if (memRdValid) begin
          ctl.capData = 1'b1;
          stateNext   = ST_PUSH;
        end
      end
      ST_PUSH: begin
        outValid = 1'b1;
        if (outReady) begin
          ctl.advance = 1'b1;
          stateNext   = stat.chunkEnd ? ST_CEND : ST_BRD;
        end
      end
      ST_CEND: begin
        ctl.commitBuf = 1'b1;
        stateNext     = ST_CHUNK;
      end
      ST_WB: begin
        memWrEn = 1'b1;
        if (wordIdx == 2'd3) begin
          wordIdxNext = '0;
          if (stat.fEol) begin
            ctl.setEol = 1'b1;
            stateNext  = ST_CRD;
          end else begin
            ctl.loadNext = 1'b1;
            stateNext    = ST_DRD;
          end
        end else begin
          wordIdxNext = wordIdx + 2'd1;
        end
      end
      ST_CRD: begin
        memRdReq  = 1'b1;
        ctl.rdSel = RD_CTX;
        stateNext = ST_CWAIT;
      end
      ST_CWAIT: begin
        ctl.rdSel = RD_CTX;
        if (memRdValid) begin
          ctl.capCtx = 1'b1;
          stateNext  = ST_CWR;
        end
      end
      ST_CWR: begin
        memWrEn   = 1'b1;
        ctl.wrSel = WR_CTX;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/chain_tx_dma.sv
module chain_tx_dma
  import chain_tx_dma_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CHUNK_BYTES = 2048
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic [ADDR_W-1:0] startDescPtr,
  input  logic [ADDR_W-1:0] startCtxPtr,
  input  logic              contPulse,
  output logic              memRdReq,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic              memRdValid,
  input  logic [31:0]       memRdData,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [31:0]       memWrData,
  output logic              outValid,
  input  logic              outReady,
  output logic [31:0]       outData,
  output logic [2:0]        outBytes,
  output logic              outLast,
  output logic              metaValid,
  output logic [15:0]       metaData,
  output logic              irqPulse,
  output logic              eolFlag,
  output logic              busy,
  output logic [ADDR_W-1:0] savedDescPtr,
  output logic [ADDR_W-1:0] savedBufPtr
);

  dp_ctrl_t ctl;
  dp_stat_t stat;
  logic     pktEnd;

  chain_tx_dma_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .contPulse  (contPulse),
    .memRdValid (memRdValid),
    .outReady   (outReady),
    .stat       (stat),
    .ctl        (ctl),
    .memRdReq   (memRdReq),
    .memWrEn    (memWrEn),
    .outValid   (outValid),
    .metaValid  (metaValid),
    .irqPulse   (irqPulse),
    .busy       (busy)
  );

  chain_tx_dma_dp #(
    .ADDR_W      (ADDR_W),
    .CHUNK_BYTES (CHUNK_BYTES)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .startPtr     (startDescPtr),
    .ctxPtrIn     (startCtxPtr),
    .memRdData    (memRdData),
    .stat         (stat),
    .memRdAddr    (memRdAddr),
    .memWrAddr    (memWrAddr),
    .memWrData    (memWrData),
    .outData      (outData),
    .outBytes     (outBytes),
    .pktEnd       (pktEnd),
    .metaData     (metaData),
    .savedDescPtr (savedDescPtr),
    .savedBufPtr  (savedBufPtr),
    .eolFlag      (eolFlag)
  );

  assign outLast = outValid && pktEnd;

endmodule

// File: rtl/chain_tx_dma_chk.sv
module chain_tx_dma_chk #(
  parameter int ADDR_W      = 32,
  parameter int CHUNK_BYTES = 2048
) (
  input logic              clk,
  input logic              rstN,
  input logic              outValid,
  input logic              outReady,
  input logic [31:0]       outData,
  input logic [2:0]        outBytes,
  input logic              outLast,
  input logic              irqPulse,
  input logic              eolFlag,
  input logic              busy,
  input logic              memRdReq,
  input logic              memWrEn,
  input logic [ADDR_W-1:0] savedBufPtr
);

  localparam int MAX_BEATS = CHUNK_BYTES / 4;

  logic [ADDR_W-1:0] prevBuf;
  int unsigned       beatCnt;

  // beats accepted since the buffer pointer last moved
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevBuf <= '0;
      beatCnt <= 0;
    end else begin
      prevBuf <= savedBufPtr;
      if (savedBufPtr != prevBuf) beatCnt <= (outValid && outReady) ? 1 : 0;
      else if (outValid && outReady) beatCnt <= beatCnt + 1;
    end
  end

  p_chunk_beats_r3: assert property (@(posedge clk) disable iff (!rstN)
    beatCnt <= MAX_BEATS);

  p_bytes_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outBytes != 3'd0 && outBytes <= 3'd4));

  p_last_valid_r4: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);

  p_irq_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse);

  p_rd_wr_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(memRdReq && memWrEn));

  p_quiet_halt_r8: assert property (@(posedge clk) disable iff (!rstN)
    (eolFlag && !busy) |-> (!outValid && !memWrEn));

  p_hold_beat_r10: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) &&
                                 $stable(outBytes) && $stable(outLast)));

endmodule

bind chain_tx_dma chain_tx_dma_chk #(
  .ADDR_W      (ADDR_W),
  .CHUNK_BYTES (CHUNK_BYTES)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .outValid    (outValid),
  .outReady    (outReady),
  .outData     (outData),
  .outBytes    (outBytes),
  .outLast     (outLast),
  .irqPulse    (irqPulse),
  .eolFlag     (eolFlag),
  .busy        (busy),
  .memRdReq    (memRdReq),
  .memWrEn     (memWrEn),
  .savedBufPtr (savedBufPtr)
);

// File: tb/chain_tx_dma_bench.sv
module chain_tx_dma_bench;

  localparam int AW = 32;
  localparam int CB = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rstN = 1'b0;
  logic          startPulse = 1'b0;
  logic [AW-1:0] startDescPtr = '0;
  logic [AW-1:0] startCtxPtr = '0;
  logic          contPulse = 1'b0;
  logic          memRdReq;
  logic [AW-1:0] memRdAddr;
  logic          memRdValid = 1'b0;
  logic [31:0]   memRdData = '0;
  logic          memWrEn;
  logic [AW-1:0] memWrAddr;
  logic [31:0]   memWrData;
  logic          outValid;
  logic          outReady = 1'b0;
  logic [31:0]   outData;
  logic [2:0]    outBytes;
  logic          outLast;
  logic          metaValid;
  logic [15:0]   metaData;
  logic          irqPulse;
  logic          eolFlag;
  logic          busy;
  logic [AW-1:0] savedDescPtr;
  logic [AW-1:0] savedBufPtr;

  chain_tx_dma #(.ADDR_W(AW), .CHUNK_BYTES(CB)) u_chain_tx_dma (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .startDescPtr(startDescPtr),
    .startCtxPtr(startCtxPtr), .contPulse(contPulse), .memRdReq(memRdReq),
    .memRdAddr(memRdAddr), .memRdValid(memRdValid), .memRdData(memRdData),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .outValid(outValid), .outReady(outReady), .outData(outData),
    .outBytes(outBytes), .outLast(outLast), .metaValid(metaValid),
    .metaData(metaData), .irqPulse(irqPulse), .eolFlag(eolFlag), .busy(busy),
    .savedDescPtr(savedDescPtr), .savedBufPtr(savedBufPtr)
  );

  // memory model, one-cycle read latency
  logic [31:0] mem [0:255];
  always @(posedge clk) begin
    memRdValid <= memRdReq;
    memRdData  <= mem[memRdAddr[9:2]];
    if (memWrEn) mem[memWrAddr[9:2]] <= memWrData;
  end

  int readyMode = 1;
  always @(posedge clk) begin
    #2;
    case (readyMode)
      0:       outReady = 1'b0;
      1:       outReady = 1'b1;
      default: outReady = 1'($urandom_range(0, 1));
    endcase
  end

  typedef struct packed { logic [31:0] d; logic [2:0] n; logic l; } beat_t;
  typedef struct packed { logic [31:0] a; logic [31:0] d; logic isCtx; } wr_t;
  beat_t       beatQ[$];
  logic [15:0] metaQ[$];
  wr_t         wrQ[$];
  logic [31:0] bufLog[$];
  logic [31:0] prevBuf = '0;

  int checks = 0;
  int fails = 0;
  int irqCount = 0;
  int irqExp = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (outValid && outReady) begin
        if (beatQ.size() == 0) chk(0, "R2", "unexpected beat", outData, 0);
        else begin
          beat_t e;
          e = beatQ.pop_front();
          chk(outData == e.d, "R2", "beat data", outData, e.d);
          chk(outBytes == e.n, "R2", "beat bytes", 32'(outBytes), 32'(e.n));
          chk(outLast == e.l, "R4", "beat last", 32'(outLast), 32'(e.l));
        end
      end
      if (metaValid) begin
        if (metaQ.size() == 0) chk(0, "R5", "unexpected meta", 32'(metaData), 0);
        else begin
          logic [15:0] m;
          m = metaQ.pop_front();
          chk(metaData == m, "R5", "meta value", 32'(metaData), 32'(m));
        end
      end
      if (memWrEn) begin
        if (wrQ.size() == 0) chk(0, "R7", "unexpected write", memWrAddr, 0);
        else begin
          wr_t w;
          w = wrQ.pop_front();
          chk(memWrAddr == w.a, w.isCtx ? "R8" : "R7", "write addr", memWrAddr, w.a);
          chk(memWrData == w.d, w.isCtx ? "R8" : "R7", "write data", memWrData, w.d);
        end
      end
      if (irqPulse) irqCount++;
      if (savedBufPtr != prevBuf) begin
        bufLog.push_back(savedBufPtr);
        prevBuf = savedBufPtr;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog R11 actual=hung expected=idle");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // independent reference walk of a chain
  task automatic model(input logic [31:0] dpIn, input logic [31:0] cp);
    logic [31:0] dp, nx, bf, fl, af;
    logic [2:0]  nb;
    bit sm, done;
    dp = dpIn; sm = 1; done = 0;
    while (!done) begin
      nx = mem[dp[9:2]];
      bf = mem[dp[9:2] + 8'd1];
      fl = mem[dp[9:2] + 8'd2];
      af = mem[dp[9:2] + 8'd3];
      if (sm) metaQ.push_back(fl[31:16]);
      sm = 0;
      for (logic [31:0] p = bf; p < af; p += 4) begin
        nb = ((af - p) >= 4) ? 3'd4 : 3'(af - p);
        beatQ.push_back('{mem[p[9:2]], nb, ((p + 32'(nb)) == af) && fl[3]});
      end
      if (fl[3]) sm = 1;
      if (fl[4]) irqExp++;
      for (int k = 0; k < 4; k++)
        wrQ.push_back('{dp + 32'(4 * k), mem[dp[9:2] + 8'(k)], 1'b0});
      if (fl[0]) begin
        wrQ.push_back('{cp + 32'd4, mem[cp[9:2] + 8'd1] | 32'h8000, 1'b1});
        done = 1;
      end else dp = nx;
    end
  endtask

  task automatic setDesc(input logic [31:0] a, input logic [31:0] nx,
                         input logic [31:0] bf, input logic [31:0] fl,
                         input logic [31:0] af);
    mem[a[9:2]]        = nx;
    mem[a[9:2] + 8'd1] = bf;
    mem[a[9:2] + 8'd2] = fl;
    mem[a[9:2] + 8'd3] = af;
    for (logic [31:0] p = bf; p < af; p += 4) mem[p[9:2]] = 32'hC0DE0000 | p;
  endtask

  task automatic pulseStart(input logic [31:0] dp, input logic [31:0] cp);
    @(negedge clk);
    startDescPtr = dp; startCtxPtr = cp; startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
  endtask

  task automatic pulseCont();
    @(negedge clk); contPulse = 1'b1;
    @(negedge clk); contPulse = 1'b0;
  endtask

  task automatic waitIdle();
    repeat (2) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic drained(input string tag);
    chk(beatQ.size() == 0, "R2", {tag, " beats left"}, 32'(beatQ.size()), 0);
    chk(metaQ.size() == 0, "R5", {tag, " meta left"}, 32'(metaQ.size()), 0);
    chk(wrQ.size() == 0, "R7", {tag, " writes left"}, 32'(wrQ.size()), 0);
    chk(irqCount == irqExp, "R6", {tag, " irq count"}, 32'(irqCount), 32'(irqExp));
  endtask

  initial begin
    logic [31:0] held;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    mem[32'h14 >> 2] = 32'h0000_0001;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !eolFlag, "R1", "busy/eol in reset", {busy, eolFlag}, 0);
    chk(!outValid && !memRdReq && !memWrEn, "R1", "strobes in reset",
        {outValid, memRdReq, memWrEn}, 0);
    chk(savedDescPtr == 0 && savedBufPtr == 0, "R1", "pointers in reset", savedBufPtr, 0);
    rstN = 1'b1;
    @(negedge clk);
    pulseCont();  // R12: continue with eolFlag clear is ignored
    repeat (4) @(negedge clk);
    chk(!busy, "R12", "continue ignored before any run", 32'(busy), 0);

    // single descriptor, odd length, packet end, irq, end of list
    setDesc(32'h40, 32'h0, 32'h200, 32'hABCD_0019, 32'h20A);
    model(32'h40, 32'h10);
    pulseStart(32'h40, 32'h10);
    waitIdle();
    drained("single");
    chk(eolFlag, "R8", "eol flag after list end", 32'(eolFlag), 1);
    chk(savedDescPtr == 32'h40, "R8", "saved desc", savedDescPtr, 32'h40);
    chk(savedBufPtr == 32'h20A, "R8", "saved buf", savedBufPtr, 32'h20A);
    chk(mem[32'h14 >> 2] == 32'h8001, "R8", "context disable bit", mem[32'h14 >> 2], 32'h8001);

    // chain with zero-length packet-end descriptor, random back-pressure
    setDesc(32'h50, 32'h60, 32'h240, 32'h0001_0000, 32'h248);
    setDesc(32'h60, 32'h70, 32'h250, 32'h0002_0008, 32'h250);
    setDesc(32'h70, 32'h0, 32'h260, 32'h0003_0019, 32'h26C);
    model(32'h50, 32'h10);
    readyMode = 2;
    pulseStart(32'h50, 32'h10);
    chk(!eolFlag, "R11", "start clears eol", 32'(eolFlag), 0);
    waitIdle();
    drained("chain R9 R13");
    chk(savedDescPtr == 32'h70, "R9", "followed next pointers", savedDescPtr, 32'h70);
    chk(eolFlag, "R8", "eol after chain", 32'(eolFlag), 1);

    // chunking: 40-byte buffer with 16-byte chunks
    readyMode = 1;
    setDesc(32'h80, 32'h90, 32'h280, 32'h0004_0009, 32'h2A8);
    model(32'h80, 32'h10);
    bufLog.delete();
    pulseStart(32'h80, 32'h10);
    waitIdle();
    drained("chunk");
    chk(bufLog.size() == 4, "R3", "chunk updates", 32'(bufLog.size()), 4);
    if (bufLog.size() == 4) begin
      chk(bufLog[0] == 32'h280, "R3", "buf at load", bufLog[0], 32'h280);
      chk(bufLog[1] == 32'h290, "R3", "first chunk", bufLog[1], 32'h290);
      chk(bufLog[2] == 32'h2A0, "R3", "second chunk", bufLog[2], 32'h2A0);
      chk(bufLog[3] == 32'h2A8, "R3", "short chunk", bufLog[3], 32'h2A8);
    end

    // continue while last descriptor still ends the list
    pulseCont();
    waitIdle();
    drained("continue-noop");
    chk(eolFlag, "R12", "eol stays after no-op continue", 32'(eolFlag), 1);
    chk(savedDescPtr == 32'h80, "R12", "desc unchanged", savedDescPtr, 32'h80);

    // extend the list, then continue
    setDesc(32'h90, 32'h0, 32'h2C0, 32'h0005_0019, 32'h2C3);
    mem[32'h88 >> 2] = 32'h0004_0008;
    model(32'h90, 32'h10);
    pulseCont();
    waitIdle();
    drained("continue-run");
    chk(savedDescPtr == 32'h90, "R12", "continue followed next", savedDescPtr, 32'h90);
    chk(eolFlag, "R12", "eol after continued run", 32'(eolFlag), 1);

    // stall plus start/continue while busy
    setDesc(32'hA0, 32'h0, 32'h300, 32'h0006_0019, 32'h310);
    model(32'hA0, 32'h10);
    readyMode = 0;
    pulseStart(32'hA0, 32'h10);
    while (!outValid) @(negedge clk);
    held = outData;
    startDescPtr = 32'h40; startPulse = 1'b1; contPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0; contPulse = 1'b0;
    repeat (5) @(negedge clk);
    chk(outValid, "R10", "valid held while stalled", 32'(outValid), 1);
    chk(outData == held, "R10", "data held while stalled", outData, held);
    readyMode = 1;
    waitIdle();
    drained("busy-ignore");
    chk(savedDescPtr == 32'hA0, "R11", "start while busy ignored", savedDescPtr, 32'hA0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule